// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. When a qualifying trigger event arrives it raises a pulse output for a programmed number of clock cycles. During that time a complementary output stays low. The analogue resistor–capacitor timing of a classic one-shot is replaced by a cycle count taken from a 16-bit width input. That width is sampled only at the moment a trigger is accepted.

There are three trigger paths:
- a falling edge on the first trigger input, allowed while the second input is high;
- a rising edge on the second trigger input, allowed while the first input is low;
- the release (rising edge) of an active-low clear input, allowed while the first input is low and the second is high.

All three triggers also require the clear to be inactive. Each trigger input passes through a two-flop synchroniser, and edges are found by comparing against the previous synchronised value. A trigger that arrives during a pulse restarts the full interval, so repeated triggering can hold the output high indefinitely. Holding the clear low ends any pulse at once and blocks every trigger.

A system reset is asserted asynchronously and released synchronously. It empties the counter. After release, edge detection stays disarmed until the synchronisers and the edge history hold the true input levels, so input levels present at release never look like edges.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A high-to-low transition on `trig_fall_i` starts a pulse only while `trig_rise_i` is high and `clear_n_i` is high.
- R2: A low-to-high transition on `trig_rise_i` starts a pulse only while `trig_fall_i` is low and `clear_n_i` is high.
- R3: A low-to-high transition on `clear_n_i` starts a pulse only while `trig_fall_i` is low and `trig_rise_i` is high.
- R4: While `clear_n_i` is low, `pulse_o` is low, `pulse_n_o` is high, and every trigger is ignored. Releasing the clear while `trig_fall_i` is high produces no pulse.
- R5: `clear_n_i` going low ends a pulse in progress two clock cycles after the input change, at any point in the interval.
- R6: An accepted trigger during a pulse reloads the full interval from the new trigger, so the pulse lasts the retrigger offset plus the width.
- R7: `pulse_n_o` is always the complement of `pulse_o`.
- R8: Input level changes that are not qualifying edges, and changes of `width_i` after the trigger, leave a running pulse at its programmed length.
- R9: A trigger input change is followed by `pulse_o` rising three clock edges later. The pulse then stays high for exactly `width_i` cycles, with `width_i` taken at the trigger.
- R10: A trigger accepted while `width_i` is 0 is ignored. It produces no pulse and does not cut a running pulse.
- R11: A trigger that is registered in the same cycle the count expires reloads the count, with no low cycle between the two intervals.
- R12: During system reset `pulse_o` is low. Input levels that are present at reset release cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| trig_fall_i | input | 1 | Trigger on falling edge, gated by `trig_rise_i` high |
| trig_rise_i | input | 1 | Trigger on rising edge, gated by `trig_fall_i` low |
| clear_n_i | input | 1 | Active-low direct clear; its release is also a trigger |
| width_i | input | 16 | Pulse length in clock cycles, sampled at trigger |
| pulse_o | output | 1 | Active-high pulse |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Input changes cross two synchroniser flops. The edge is then seen combinationally and loaded into the counter, so `pulse_o` is first high at the third clock edge after a trigger input change. A clear going low reaches the output at the second edge. The bench drives inputs just after a falling clock edge and samples at each following falling edge, counting sample indices from the stimulus. From those indices it checks the first high sample (index 3), the number of high samples, the absence of gaps, and the complement on every sample. Retrigger and expiry cases place their second edge at an offset chosen so the reload lands on a known cycle, and the expected length is that offset plus the width.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Index of each synchronised level inside the shared input vector.
  localparam int unsigned IDX_FALL  = 0;
  localparam int unsigned IDX_RISE  = 1;
  localparam int unsigned IDX_CLEAR = 2;
  localparam int unsigned N_LEVELS  = 3;

  // Which trigger path fired in the current cycle.
  typedef struct packed {
    logic clear_rise;
    logic rise_b;
    logic fall_a;
  } trig_src_t;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  logic [STAGES-1:0][N-1:0] stage_q;
  logic [STAGES-1:0][N-1:0] stage_d;

  // Shift chain: each stage takes the one before it.
  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
  import oneshot_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LEVELS-1:0] lvl_i,
  output logic                trig_o,
  output trig_src_t           src_o
);

  // The edge history is valid once the synchroniser and the history
  // register both hold real input levels.
  localparam int unsigned SETTLE = STAGES + 1;
  localparam int unsigned SW     = $clog2(SETTLE + 1);

  logic [N_LEVELS-1:0] hist_q;
  logic [SW-1:0]       settle_q, settle_d;
  logic                settled;
  logic                settle_en;

  assign settled   = (settle_q == SW'(SETTLE));
  assign settle_en = !settled;
  assign settle_d  = settle_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (settle_en) begin
      settle_q <= settle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= lvl_i;
    end
  end

  logic a_lvl, b_lvl, c_lvl;
  assign a_lvl = lvl_i[IDX_FALL];
  assign b_lvl = lvl_i[IDX_RISE];
  assign c_lvl = lvl_i[IDX_CLEAR];

  always_comb begin
    src_o            = '0;
    src_o.fall_a     = settled &  hist_q[IDX_FALL]  & ~a_lvl &  b_lvl & c_lvl;
    src_o.rise_b     = settled & ~hist_q[IDX_RISE]  &  b_lvl & ~a_lvl & c_lvl;
    src_o.clear_rise = settled & ~hist_q[IDX_CLEAR] &  c_lvl & ~a_lvl & b_lvl;
    trig_o           = |src_o;
  end

  // Once armed after reset, detection stays armed (R12).
  p_stay_armed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             clear_lvl_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             active_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             load;
  logic             running;

  assign running = (cnt_q != '0);
  assign load    = trig_i && (width_i != '0);

  // Priority: clear, then reload, then count down.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!clear_lvl_i) begin
      cnt_d  = '0;
      cnt_en = running;
    end else if (load) begin
      cnt_d  = width_i;
      cnt_en = 1'b1;
    end else if (running) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = running & clear_lvl_i;

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && width_i != '0) |=> (cnt_q == $past(width_i)));

  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_lvl_i && !trig_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_lvl_i |=> (cnt_q == '0));

endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_fall_i,
  input  logic             trig_rise_i,
  input  logic             clear_n_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  logic [N_LEVELS-1:0] raw_lvl;
  logic [N_LEVELS-1:0] sync_lvl;
  logic                trig;
  trig_src_t           trig_src;

  always_comb begin
    raw_lvl            = '0;
    raw_lvl[IDX_FALL]  = trig_fall_i;
    raw_lvl[IDX_RISE]  = trig_rise_i;
    raw_lvl[IDX_CLEAR] = clear_n_i;
  end

  oneshot_sync #(
    .N      (N_LEVELS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lvl),
    .sync_o  (sync_lvl)
  );

  oneshot_edge #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sync_lvl),
    .trig_o (trig),
    .src_o  (trig_src)
  );

  oneshot_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig),
    .clear_lvl_i (sync_lvl[IDX_CLEAR]),
    .width_i     (width_i),
    .active_o    (pulse_o)
  );

  assign pulse_n_o = ~pulse_o;

  // A registered trigger keeps or raises the output with no gap (R11).
  p_no_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && width_i != '0) |=> pulse_o);

endmodule

// File: tb/oneshot_pulse_gen_bench.sv
`timescale 1ns/1ps
module oneshot_pulse_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tb_a, tb_b, tb_clr;
  logic [15:0] tb_w;
  logic        pulse, pulse_n;

  int checks = 0;
  int fails  = 0;
  int idx, hi_cnt, first_hi, gap, comp_bad;
  bit ended;

  always #2 clk = ~clk;

  oneshot_pulse_gen u_oneshot_pulse_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_fall_i (tb_a),
    .trig_rise_i (tb_b),
    .clear_n_i   (tb_clr),
    .width_i     (tb_w),
    .pulse_o     (pulse),
    .pulse_n_o   (pulse_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idx++;
      if (pulse_n !== ~pulse) comp_bad++;
      if (pulse) begin
        if (ended) gap = 1;
        hi_cnt++;
        if (first_hi < 0) first_hi = idx;
      end else if (first_hi >= 0) begin
        ended = 1'b1;
      end
    end
  endtask

  task automatic win_start();
    idx = 0; hi_cnt = 0; first_hi = -1; gap = 0; comp_bad = 0; ended = 1'b0;
  endtask

  task automatic settle(input logic a, input logic b, input logic c);
    tb_w = 16'd0; tb_a = a; tb_b = b; tb_clr = c;
    step(6);
  endtask

  task automatic win_end(input int exp_hi, input string req);
    check(hi_cnt == exp_hi, req, "high cycles", hi_cnt, exp_hi);
    check(gap == 0, req, "gap in pulse", gap, 0);
    check(comp_bad == 0, "R7", "complement mismatches", comp_bad, 0);
  endtask

  task automatic t_reset();
    tb_a = 1'b0; tb_b = 1'b1; tb_clr = 1'b1; tb_w = 16'd5;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse == 1'b0 && pulse_n == 1'b1, "R12", "pulse in reset", pulse, 0);
    rst_n = 1'b1;
    win_start();
    step(12);
    win_end(0, "R12");
  endtask

  task automatic t_fall_a();
    settle(1, 1, 1); tb_w = 16'd5; win_start();
    tb_a = 1'b0; step(14);
    check(first_hi == 3, "R9", "first high sample", first_hi, 3);
    win_end(5, "R1");
    settle(1, 0, 1); tb_w = 16'd5; win_start();
    tb_a = 1'b0; step(12);
    win_end(0, "R1");
  endtask

  task automatic t_rise_b();
    settle(0, 0, 1); tb_w = 16'd7; win_start();
    tb_b = 1'b1; step(15);
    check(first_hi == 3, "R2", "first high sample", first_hi, 3);
    win_end(7, "R2");
    settle(1, 0, 1); tb_w = 16'd7; win_start();
    tb_b = 1'b1; step(12);
    win_end(0, "R2");
  endtask

  task automatic t_clear_rise();
    settle(0, 1, 0); tb_w = 16'd4; win_start();
    tb_clr = 1'b1; step(12);
    check(first_hi == 3, "R3", "first high sample", first_hi, 3);
    win_end(4, "R3");
    settle(1, 1, 0); tb_w = 16'd4; win_start();
    tb_clr = 1'b1; step(12);
    win_end(0, "R3");
  endtask

  task automatic t_clear_cut();
    settle(1, 1, 1); tb_w = 16'd20; win_start();
    tb_a = 1'b0; step(5);
    tb_clr = 1'b0; step(10);
    win_end(4, "R5");
    check(pulse == 1'b0 && pulse_n == 1'b1, "R4", "outputs under clear",
          pulse, 0);
    tb_a = 1'b1; step(4);
    tb_a = 1'b0; step(10);
    check(hi_cnt == 4, "R4", "trigger under clear", hi_cnt, 4);
    tb_a = 1'b1; step(3);
    tb_clr = 1'b1; step(10);
    check(hi_cnt == 4, "R4", "release with A high", hi_cnt, 4);
  endtask

  task automatic t_retrigger();
    settle(0, 0, 1); tb_w = 16'd6; win_start();
    tb_b = 1'b1; step(4);
    tb_b = 1'b0; step(1);
    tb_b = 1'b1; step(20);
    win_end(11, "R6");
  endtask

  task automatic t_expiry();
    settle(0, 0, 1); tb_w = 16'd4; win_start();
    tb_b = 1'b1; step(3);
    tb_b = 1'b0; step(1);
    tb_b = 1'b1; step(16);
    win_end(8, "R11");
  endtask

  task automatic t_widths();
    settle(1, 1, 1); tb_w = 16'd1; win_start();
    tb_a = 1'b0; step(8);
    win_end(1, "R9");
    settle(1, 1, 1); tb_w = 16'd0; win_start();
    tb_a = 1'b0; step(10);
    win_end(0, "R10");
    settle(0, 0, 1); tb_w = 16'd8; win_start();
    tb_b = 1'b1; step(3);
    tb_b = 1'b0; step(1);
    tb_w = 16'd0; tb_b = 1'b1; step(15);
    win_end(8, "R10");
  endtask

  task automatic t_static();
    settle(1, 1, 1); tb_w = 16'd9; win_start();
    tb_a = 1'b0; step(4);
    tb_w = 16'd2; tb_b = 1'b0; step(2);
    tb_a = 1'b1; step(2);
    tb_b = 1'b1; step(15);
    win_end(9, "R8");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fall_a();
    t_rise_b();
    t_clear_rise();
    t_clear_cut();
    t_retrigger();
    t_expiry();
    t_widths();
    t_static();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule